// File: doc/BRIEF.md
# Windowed Wheel Speed Counter

This block measures shaft or sprocket rotation rate by counting pulses from a rotation sensor (Hall-effect transducer or optical interrupter) over a fixed sample window. The sensor line is asynchronous. It is brought into the system clock domain through a flop chain, and only its rising transitions are counted. An internal timebase derived from the system clock marks the end of each window. At that instant the running total is copied into a read register and the running counter restarts from zero in the same cycle.

The processor reads the latched total, the live total or the window length through a small registered read port. A sticky ready flag shows that a fresh sample is waiting, and a read of the latched total clears it. The window length is a clock-cycle count held in a register. Its reset value gives 500 ms at the configured clock rate, and software may load a new value. Distance, slip and current checks are done in software from the sampled totals.

Top module: `wheel_rate_counter`

## Requirements
- R1: Each rising transition of `sensor_in` adds exactly one to the running count. A steady level and a falling transition add nothing.
- R2: `sensor_in` passes through SYNC_STAGES flops (default 2) and an edge detector. A rise set up before clock edge k is counted at edge k+2, so a live read that samples at edge k+2 returns the old total and a read at edge k+3 returns the new one. A high pulse of any length counts once.
- R3: At a window boundary the running count is copied into the latched register and the running count is cleared in the same clock edge.
- R4: A boundary occurs once every `win_len` clock cycles, counted from the last length write or from reset. The reset value of `win_len` is CLK_HZ/1000*WINDOW_MS, which is 100,000,000 at the defaults.
- R5: `sample_ready` is set by every boundary and stays set until a read with `rd_addr` = 0 clears it at that read's clock edge. If a boundary and such a read fall in the same cycle, the flag stays set. Reads at other addresses leave the flag unchanged.
- R6: The running count saturates at all ones (2**COUNT_W-1) and does not wrap.
- R7: A length write (`cfg_we` high) restarts the window and clears the running count. It does not latch a sample and does not change `sample_ready`.
- R8: A written length below MIN_WIN (default 2) is stored as MIN_WIN.
- R9: A sensor edge counted in the same cycle as a boundary goes into the new window. The closing sample excludes it and the new running count starts at 1.
- R10: When `rd_en` is high at a clock edge, `rd_data` takes the value selected by `rd_addr`: 0 gives the latched count, 1 the live running count, 2 the window length, 3 zero. Counts are zero-extended. Otherwise `rd_data` holds its value.
- R11: After reset the running count, the latched count, `sample_ready` and `rd_data` are zero, and the window length holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sensor_in | input | 1 | Asynchronous pulse from the rotation sensor |
| cfg_we | input | 1 | Load `cfg_len` as the new window length and restart the window |
| cfg_len | input | WIN_W | Window length in clock cycles |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read select: 0 latched, 1 live, 2 window length, 3 zero |
| rd_data | output | DATA_W | Registered read data, DATA_W = max(COUNT_W, WIN_W) |
| sample_ready | output | 1 | Sticky flag: a new latched sample is waiting |

## Verification
The assertions assume that `sensor_in` is a plain level signal whose high and low phases each last longer than one clock. A shorter glitch can be missed by the synchronizer, and the edge and step properties would not describe that case. They also assume that `cfg_len` carries an intended cycle count whenever `cfg_we` is high. The bench drives the sensor only at falling clock edges, with at least four cycles per phase, and it writes only explicit lengths. The coincidence case is placed by counting clock edges from the length write, so the counted edge lands exactly on the boundary cycle. A second instance with a 4-bit counter exercises saturation with a short pulse train.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

   // read-port selector codes
   typedef enum logic [1:0] {
      SEL_LATCHED = 2'd0,
      SEL_LIVE    = 2'd1,
      SEL_WINLEN  = 2'd2,
      SEL_NONE    = 2'd3
   } wrc_sel_e;

   function automatic int wrc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wrc_edge_sync.sv
module wrc_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("wrc_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain;
   logic                   prev_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[SYNC_STAGES-1];
   end

   assign rise_o = chain[SYNC_STAGES-1] & ~prev_q;

   // R2: one detected edge per rising transition, never two cycles in a row
   p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/wrc_window_timer.sv
module wrc_window_timer #(
   parameter int          WIN_W       = 32,
   parameter longint      DEFAULT_LEN = 100_000_000,
   parameter int          MIN_LEN     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [WIN_W-1:0] cfg_len,
   output logic [WIN_W-1:0] win_len_o,
   output logic             boundary_o
);

   localparam logic [WIN_W-1:0] LEN_RST = WIN_W'(DEFAULT_LEN);
   localparam logic [WIN_W-1:0] LEN_MIN = WIN_W'(MIN_LEN);

   generate
      if (MIN_LEN < 2) begin : g_bad_min
         $error("wrc_window_timer: MIN_LEN must be at least 2");
      end
      if (DEFAULT_LEN < longint'(MIN_LEN)) begin : g_bad_def
         $error("wrc_window_timer: DEFAULT_LEN below MIN_LEN");
      end
      if (WIN_W < 63 && DEFAULT_LEN >= (longint'(1) << WIN_W)) begin : g_bad_fit
         $error("wrc_window_timer: DEFAULT_LEN does not fit WIN_W");
      end
   endgenerate

   logic [WIN_W-1:0] len_q;
   logic [WIN_W-1:0] tick_q;
   logic             at_end;

   assign at_end     = (tick_q == len_q - WIN_W'(1));
   assign boundary_o = at_end && !cfg_we;
   assign win_len_o  = len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= LEN_RST;
         tick_q <= '0;
      end else if (cfg_we) begin
         len_q  <= (cfg_len < LEN_MIN) ? LEN_MIN : cfg_len;
         tick_q <= '0;
      end else if (at_end) begin
         tick_q <= '0;
      end else begin
         tick_q <= tick_q + WIN_W'(1);
      end
   end

   // R4: the cycle position always stays inside the programmed window
   p_tick_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q < len_q);
   // R8: the stored length never drops below the floor
   p_len_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      len_q >= LEN_MIN);

endmodule

// File: rtl/wrc_sat_counter.sv
module wrc_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         inc,
   output logic [W-1:0] count_o
);

   localparam logic [W-1:0] ALL_ONES = '1;

   generate
      if (W < 2) begin : g_bad_w
         $error("wrc_sat_counter: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          count_o <= '0;
      else if (clear)                      count_o <= inc ? W'(1) : '0;
      else if (inc && count_o != ALL_ONES) count_o <= count_o + W'(1);
   end

   // R6: a full counter stays full until it is cleared
   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == ALL_ONES && !clear) |=> count_o == ALL_ONES);
   // R1: without a clear the count moves by at most one per cycle
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && count_o != ALL_ONES) |=>
         (count_o == $past(count_o) || count_o == $past(count_o) + W'(1)));

endmodule

// File: rtl/wheel_rate_counter.sv
module wheel_rate_counter
   import wrc_pkg::*;
#(
   parameter  longint CLK_HZ      = 200_000_000,
   parameter  int     WINDOW_MS   = 500,
   parameter  int     COUNT_W     = 32,
   parameter  int     WIN_W       = 32,
   parameter  int     SYNC_STAGES = 2,
   parameter  int     MIN_WIN     = 2,
   localparam int     DATA_W      = wrc_max(COUNT_W, WIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sensor_in,
   input  logic              cfg_we,
   input  logic [WIN_W-1:0]  cfg_len,
   input  logic              rd_en,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              sample_ready
);

   localparam longint WIN_RST = (CLK_HZ / 1000) * longint'(WINDOW_MS);

   generate
      if (WINDOW_MS < 1) begin : g_bad_ms
         $error("wheel_rate_counter: WINDOW_MS must be positive");
      end
   endgenerate

   logic               rise;
   logic               boundary;
   logic [WIN_W-1:0]   win_len;
   logic [COUNT_W-1:0] live_cnt;
   logic [COUNT_W-1:0] held_cnt;
   logic               clr_run;
   wrc_sel_e           sel;

   wrc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sensor_in),
      .rise_o   (rise)
   );

   wrc_window_timer #(
      .WIN_W       (WIN_W),
      .DEFAULT_LEN (WIN_RST),
      .MIN_LEN     (MIN_WIN)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_len    (cfg_len),
      .win_len_o  (win_len),
      .boundary_o (boundary)
   );

   assign clr_run = boundary | cfg_we;

   wrc_sat_counter #(.W(COUNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clr_run),
      .inc     (rise),
      .count_o (live_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held_cnt <= '0;
      else if (boundary) held_cnt <= live_cnt;
   end

   assign sel = wrc_sel_e'(rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               sample_ready <= 1'b0;
      else if (boundary)                        sample_ready <= 1'b1;
      else if (rd_en && sel == SEL_LATCHED)     sample_ready <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         unique case (sel)
            SEL_LATCHED: rd_data <= DATA_W'(held_cnt);
            SEL_LIVE:    rd_data <= DATA_W'(live_cnt);
            SEL_WINLEN:  rd_data <= DATA_W'(win_len);
            default:     rd_data <= '0;
         endcase
      end
   end

   // R3: the sample taken at a boundary is the count that closed the window
   p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> held_cnt == $past(live_cnt));
   // R3, R9: after a boundary the running count holds only an edge from that cycle
   p_restart_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> live_cnt == COUNT_W'($past(rise)));
   // R5: a boundary always leaves the ready flag set
   p_ready_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> sample_ready);
   // R7: a length write keeps the previous sample
   p_write_keeps_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> $stable(held_cnt));

endmodule

// File: tb/tb_wheel_rate_counter.sv
`timescale 1ns/1ps
module tb_wheel_rate_counter;

   localparam int WIN_W = 32;
   localparam int NV    = 5;
   localparam int VEC_LEN [NV] = '{32, 48, 200, 96, 400};
   localparam int VEC_N   [NV] = '{0, 3, 20, 11, 40};
   localparam int NARROW_MAX = 15;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sensor_in = 1'b0;
   logic             cfg_we = 1'b0;
   logic [WIN_W-1:0] cfg_len = '0;
   logic             rd_en = 1'b0;
   logic [1:0]       rd_addr = 2'd0;
   logic [31:0]      rd_data, rd_data_n;
   logic             sample_ready, sample_ready_n;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wheel_rate_counter dut (
      .clk(clk), .rst_n(rst_n), .sensor_in(sensor_in), .cfg_we(cfg_we),
      .cfg_len(cfg_len), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .sample_ready(sample_ready));

   wheel_rate_counter #(.COUNT_W(4)) dut_narrow (
      .clk(clk), .rst_n(rst_n), .sensor_in(sensor_in), .cfg_we(cfg_we),
      .cfg_len(cfg_len), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data_n), .sample_ready(sample_ready_n));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input int len);
      @(negedge clk);
      cfg_we  = 1'b1;
      cfg_len = WIN_W'(len);
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   task automatic do_read(input int addr);
      @(negedge clk);
      rd_en   = 1'b1;
      rd_addr = 2'(addr);
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) sensor_in = 1'b1;
         repeat (4) @(negedge clk);
         sensor_in = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic wait_ready(input string req);
      int t = 0;
      @(negedge clk);
      while (!sample_ready && t < 5000) begin
         @(negedge clk);
         t++;
      end
      check(sample_ready, req, sample_ready, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11: reset state
      @(negedge clk);
      check(rd_data == 0, "R11 rd_data", rd_data, 0);
      check(sample_ready == 0, "R11 ready", sample_ready, 0);
      do_read(2);
      check(rd_data == 100_000_000, "R11 R4 window reset value", rd_data, 100_000_000);
      do_read(0);
      check(rd_data == 0, "R11 latched", rd_data, 0);
      do_read(3);
      check(rd_data == 0, "R10 unused address", rd_data, 0);

      // vector table: length, pulse count -> latched totals (R1 R3 R4 R6 R10 R5)
      for (int v = 0; v < NV; v++) begin
         int expn;
         cfg_write(VEC_LEN[v]);
         do_read(0);
         pulses(VEC_N[v]);
         wait_ready("R4 boundary reached");
         do_read(1);
         check(sample_ready == 1, "R5 live read keeps ready", sample_ready, 1);
         do_read(0);
         check(rd_data == VEC_N[v], "R1 R3 latched count", rd_data, VEC_N[v]);
         expn = (VEC_N[v] > NARROW_MAX) ? NARROW_MAX : VEC_N[v];
         check(rd_data_n == expn, "R6 saturated count", rd_data_n, expn);
         @(negedge clk);
         check(sample_ready == 0, "R5 read clears ready", sample_ready, 0);
      end

      // R2: latency and single count for a long pulse; R1 falling edge ignored
      cfg_write(2000);
      @(negedge clk);
      sensor_in = 1'b1;
      rd_en = 1'b1;
      rd_addr = 2'd1;
      repeat (3) @(posedge clk);
      #1 check(rd_data == 0, "R2 not yet counted at k+2", rd_data, 0);
      @(posedge clk);
      #1 check(rd_data == 1, "R2 counted by k+3", rd_data, 1);
      rd_en = 1'b0;
      repeat (20) @(negedge clk);
      do_read(1);
      check(rd_data == 1, "R2 long pulse counts once", rd_data, 1);
      @(negedge clk) sensor_in = 1'b0;
      repeat (6) @(negedge clk);
      do_read(1);
      check(rd_data == 1, "R1 falling edge ignored", rd_data, 1);

      // R9: edge counted on the boundary cycle goes to the new window
      begin
         int e0;
         cfg_write(100);
         e0 = cyc;
         do_read(0);
         pulses(2);
         while (cyc < e0 + 97) begin
            @(posedge clk);
            #1;
         end
         sensor_in = 1'b1;
         wait_ready("R9 first boundary");
         do_read(0);
         check(rd_data == 2, "R9 closing sample excludes edge", rd_data, 2);
         @(negedge clk) sensor_in = 1'b0;
         wait_ready("R9 second boundary");
         do_read(0);
         check(rd_data == 1, "R9 edge lands in new window", rd_data, 1);
      end

      // R7: a write restarts the window, clears the count, latches nothing
      cfg_write(60);
      do_read(0);
      pulses(3);
      cfg_write(60);
      do_read(1);
      check(rd_data == 0, "R7 write clears running count", rd_data, 0);
      check(sample_ready == 0, "R7 write sets no sample", sample_ready, 0);
      pulses(2);
      wait_ready("R7 boundary after restart");
      do_read(0);
      check(rd_data == 2, "R7 only post-write pulses", rd_data, 2);

      // R8: length below floor is clamped
      cfg_write(0);
      do_read(2);
      check(rd_data == 2, "R8 clamp to minimum", rd_data, 2);
      cfg_write(1);
      do_read(2);
      check(rd_data == 2, "R8 clamp of one", rd_data, 2);
      cfg_write(1000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule